// File: doc/BRIEF.md
# Frame Buffer Fetch Engine with Palette Loading

This block feeds a display raster engine from memory. When the raster is switched on it walks an address window in memory, one word (four bytes) at a time. Reads go out as bursts over a simple request/acknowledge read port, and the returned words are pushed into a pixel FIFO. The raster engine pops words from that FIFO. Before the pixel data, the block can also fetch a colour palette from the start of the window. Palette words leave on a separate write port, indexed from zero. A two-bit load mode selects one of three sequences: palette followed by pixels, palette alone, or pixels alone.

Two buffers are supported, each described by a base address and an inclusive ceiling address. Either the engine keeps replaying buffer 0, or it alternates between buffer 0 and buffer 1. Buffer addresses are copied into working registers at every frame start, so software can rewrite a buffer while that buffer is being fetched. Events are recorded in a status word whose bits are cleared by writing ones. Three enable bits combine those events into one interrupt line.

Register indices on the write port are: 0 control, 1 fetch setup, 2 status, 3 base 0, 4 ceiling 0, 5 base 1, 6 ceiling 1.

Top module: `frame_fetch_dma`

## Requirements
- R1: After reset, `statusOut` is zero, `irq` is low, `rdReq` is low and `pixAvail` is low.
- R2: In pixel-only mode (control bits 21:20 = 2, or 3), each frame delivers the words from base up to and including ceiling, in rising address order, to `pixData`. Completing a frame of buffer 0 sets status bit 8. With alternation off, every frame uses buffer 0.
- R3: Setup bits 6:4 give the burst length: codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 words, and any larger code means 16 words. Each request asks for the smaller of the burst length and the words left in the phase. `rdReq`, `rdAddr` and `rdLen` hold steady until `rdAck`.
- R4: With setup bit 0 set, frames alternate between buffer 0 and buffer 1, starting with buffer 0. Completing a frame of buffer 1 sets status bit 9.
- R5: In palette-plus-pixel mode (control bits 21:20 = 0), each frame first sends the palette words found at base to the palette port, with indices 0, 1, 2 and so on. The pixel words that follow begin right after the palette. The end of the palette sets status bit 6.
- R6: In palette-only mode (control bits 21:20 = 1), the palette is fetched once and status bit 6 is set. No pixel word and no further read request follows until the raster is re-enabled.
- R7: Control bit 22 sets the palette size: 0 gives 32 bytes (8 words), 1 gives 512 bytes (128 words).
- R8: Writing to status index 2 clears each status bit written as one. Bits written as zero are left unchanged.
- R9: Writes to base and ceiling registers take effect at the next frame start of that buffer. The frame already in progress completes from the old window.
- R10: A pop request (`pixRd`) while the FIFO is empty and the raster is enabled (control bit 0) sets status bit 5.
- R11: A `lineStart` pulse sets status bit 2 when the FIFO is empty and an underflow has occurred since the previous `lineStart`. Without such an underflow it leaves bit 2 alone.
- R12: `irq` is the OR of three terms: (bit 6 AND control bit 4), ((bit 8 OR bit 9) AND setup bit 2), and ((bit 5 OR bit 2) AND control bit 6).
- R13: While control bit 0 is clear, no read request is issued and the FIFO stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWrData | input | 32 | Register write data |
| rdReq | output | 1 | Burst read request, held until acknowledged |
| rdAddr | output | 32 | Byte address of the first word of the burst |
| rdLen | output | LEN_W | Words in the burst |
| rdAck | input | 1 | Request accepted |
| rspValid | input | 1 | One returned word is valid |
| rspData | input | 32 | Returned word |
| palWrEn | output | 1 | Palette word write strobe |
| palWrIdx | output | 7 | Palette word index |
| palWrData | output | 32 | Palette word |
| pixRd | input | 1 | Pop one pixel word |
| pixData | output | 32 | Word at the head of the FIFO |
| pixAvail | output | 1 | FIFO not empty |
| lineStart | input | 1 | Raster line start pulse |
| statusOut | output | 32 | Status word |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the block with a 16-word FIFO and the default 5-bit length field. With this size a 16-word burst needs the FIFO to drain completely, so the gating of requests on free space is exercised at its limit. The bench sweeps every burst code, including an out-of-range one, against windows shorter than, longer than and equal to one burst. Short windows keep the alternating-buffer sequence, the palette offset and the mid-frame window swap within a few dozen cycles. A one-word burst with a delayed acknowledge exercises the request-hold rule.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_SETUP = 3'd1;
  localparam logic [2:0] REG_STAT  = 3'd2;
  localparam logic [2:0] REG_BASE0 = 3'd3;
  localparam logic [2:0] REG_CEIL0 = 3'd4;
  localparam logic [2:0] REG_BASE1 = 3'd5;
  localparam logic [2:0] REG_CEIL1 = 3'd6;

  localparam logic [1:0] MODE_PAL_PIX = 2'd0;
  localparam logic [1:0] MODE_PAL_ONLY = 2'd1;

  localparam int PAL_SMALL_BYTES = 16 * 2;
  localparam int PAL_LARGE_BYTES = 256 * 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FSTART, ST_LOAD, ST_PAL, ST_DATA, ST_HALT
  } fetchState_t;

  typedef struct packed {
    logic frameStart;
    logic bufSel;
    logic startPal;
    logic startData;
    logic contData;
    logic issue;
    logic palDone;
    logic eof0;
    logic eof1;
  } fetchCmd_t;
endpackage

// File: rtl/fetch_dp.sv
module fetch_dp
  import fetch_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  input  fetchCmd_t        cmd,
  output logic             rdReq,
  output logic [31:0]      rdAddr,
  output logic [LEN_W-1:0] rdLen,
  input  logic             rdAck,
  input  logic             rspValid,
  input  logic [31:0]      rspData,
  output logic             palWrEn,
  output logic [6:0]       palWrIdx,
  output logic [31:0]      palWrData,
  input  logic             pixRd,
  output logic [31:0]      pixData,
  output logic             pixAvail,
  input  logic             lineStart,
  output logic [31:0]      statusOut,
  output logic             irq,
  output logic             rasterEn,
  output logic [1:0]       loadMode,
  output logic             dualEn,
  output logic             windowEmpty,
  output logic             respIdle,
  output logic             canIssue
);
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [31:0] PAL_SMALL_WORDS = 32'(PAL_SMALL_BYTES / 4);
  localparam logic [31:0] PAL_LARGE_WORDS = 32'(PAL_LARGE_BYTES / 4);

  logic palLarge, palIrqEn, ufIrqEn, eofIrqEn;
  logic [2:0] burstCode;
  logic [31:0] base0, ceil0, base1, ceil1, actBase, actCeil;
  logic [31:0] curAddr, wordsLeft, totalWords, palWords, thisLen32;
  logic [LEN_W-1:0] burstWords, respLeft;
  logic toPal;
  logic [6:0] palIdx;
  logic staPal, staUf, staSync, staEof0, staEof1, ufPend;

  logic [31:0] fifoMem [FIFO_DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic push, pop, underflow, syncLost, accept;

  // Burst code decode; codes beyond the table saturate at 16 words
  always_comb begin
    case (burstCode)
      3'd0:    burstWords = LEN_W'(1);
      3'd1:    burstWords = LEN_W'(2);
      3'd2:    burstWords = LEN_W'(4);
      3'd3:    burstWords = LEN_W'(8);
      default: burstWords = LEN_W'(16);
    endcase
  end

  assign totalWords  = (actCeil - actBase + 32'd1) >> 2;
  assign palWords    = palLarge ? PAL_LARGE_WORDS : PAL_SMALL_WORDS;
  assign thisLen32   = (wordsLeft < 32'(burstWords)) ? wordsLeft : 32'(burstWords);
  assign windowEmpty = (wordsLeft == 32'd0);
  assign respIdle    = (respLeft == '0) && !rdReq;
  assign canIssue    = rasterEn && !windowEmpty && respIdle &&
                       (toPal || (32'(CW'(FIFO_DEPTH) - count) >= thisLen32));

  assign accept    = rspValid && (respLeft != '0);
  assign push      = accept && !toPal && rasterEn;
  assign pop       = pixRd && (count != '0);
  assign underflow = pixRd && (count == '0) && rasterEn;
  assign syncLost  = lineStart && ufPend && (count == '0) && rasterEn;
  assign pixData   = fifoMem[rdPtr];
  assign pixAvail  = (count != '0);

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasterEn <= 1'b0; palIrqEn <= 1'b0; ufIrqEn <= 1'b0;
      loadMode <= 2'd0; palLarge <= 1'b0;
      dualEn <= 1'b0; eofIrqEn <= 1'b0; burstCode <= 3'd0;
      base0 <= '0; ceil0 <= '0; base1 <= '0; ceil1 <= '0;
    end else if (regWr) begin
      case (regAddr)
        REG_CTRL: begin
          rasterEn <= regWrData[0];
          palIrqEn <= regWrData[4];
          ufIrqEn  <= regWrData[6];
          loadMode <= regWrData[21:20];
          palLarge <= regWrData[22];
        end
        REG_SETUP: begin
          dualEn    <= regWrData[0];
          eofIrqEn  <= regWrData[2];
          burstCode <= regWrData[6:4];
        end
        REG_BASE0: base0 <= regWrData;
        REG_CEIL0: ceil0 <= regWrData;
        REG_BASE1: base1 <= regWrData;
        REG_CEIL1: ceil1 <= regWrData;
        default: ;
      endcase
    end
  end

  // Address generation and burst requests
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actBase <= '0; actCeil <= '0; curAddr <= '0; wordsLeft <= '0;
      respLeft <= '0; toPal <= 1'b0; palIdx <= '0;
      rdReq <= 1'b0; rdAddr <= '0; rdLen <= '0;
      palWrEn <= 1'b0; palWrIdx <= '0; palWrData <= '0;
    end else begin
      palWrEn <= 1'b0;
      if (cmd.frameStart) begin
        actBase <= cmd.bufSel ? base1 : base0;
        actCeil <= cmd.bufSel ? ceil1 : ceil0;
      end
      if (cmd.startPal) begin
        curAddr   <= actBase;
        wordsLeft <= palWords;
        toPal     <= 1'b1;
        palIdx    <= '0;
      end
      if (cmd.startData) begin
        toPal <= 1'b0;
        if (cmd.contData) begin
          wordsLeft <= (totalWords > palWords) ? totalWords - palWords : 32'd0;
        end else begin
          curAddr   <= actBase;
          wordsLeft <= totalWords;
        end
      end
      if (cmd.issue) begin
        rdReq     <= 1'b1;
        rdAddr    <= curAddr;
        rdLen     <= LEN_W'(thisLen32);
        curAddr   <= curAddr + (thisLen32 << 2);
        wordsLeft <= wordsLeft - thisLen32;
        respLeft  <= LEN_W'(thisLen32);
      end else if (rdReq && rdAck) begin
        rdReq <= 1'b0;
      end
      if (accept) begin
        respLeft <= respLeft - LEN_W'(1);
        if (toPal) begin
          palWrEn   <= 1'b1;
          palWrIdx  <= palIdx;
          palWrData <= rspData;
          palIdx    <= palIdx + 7'd1;
        end
      end
    end
  end

  // Pixel FIFO, flushed while the raster is off
  always_ff @(posedge clk) begin
    if (push) fifoMem[wrPtr] <= rspData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rasterEn) begin
      wrPtr <= '0; rdPtr <= '0; count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + PW'(1);
      if (pop)  rdPtr <= rdPtr + PW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // Status flags: hardware sets, write-one clears, set wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      staPal <= 1'b0; staUf <= 1'b0; staSync <= 1'b0;
      staEof0 <= 1'b0; staEof1 <= 1'b0; ufPend <= 1'b0;
    end else begin
      logic [31:0] clr;
      clr = (regWr && regAddr == REG_STAT) ? regWrData : 32'd0;
      staPal  <= (staPal  && !clr[6]) || cmd.palDone;
      staUf   <= (staUf   && !clr[5]) || underflow;
      staSync <= (staSync && !clr[2]) || syncLost;
      staEof0 <= (staEof0 && !clr[8]) || cmd.eof0;
      staEof1 <= (staEof1 && !clr[9]) || cmd.eof1;
      ufPend  <= underflow || (ufPend && !lineStart);
    end
  end

  always_comb begin
    statusOut    = '0;
    statusOut[2] = staSync;
    statusOut[5] = staUf;
    statusOut[6] = staPal;
    statusOut[8] = staEof0;
    statusOut[9] = staEof1;
  end

  assign irq = (staPal && palIrqEn) || ((staEof0 || staEof1) && eofIrqEn) ||
               ((staUf || staSync) && ufIrqEn);
endmodule

// File: rtl/fetch_ctl.sv
module fetch_ctl
  import fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasterEn,
  input  logic [1:0] loadMode,
  input  logic       dualEn,
  input  logic       windowEmpty,
  input  logic       respIdle,
  input  logic       canIssue,
  output fetchCmd_t  cmd
);
  fetchState_t state, nxt;
  logic curBuf, nxtBuf;
  logic phaseDone;

  assign phaseDone = windowEmpty && respIdle;

  always_comb begin
    cmd = '0;
    nxt = state;
    nxtBuf = curBuf;
    if (!rasterEn) begin
      if (respIdle) begin
        nxt = ST_IDLE;
        nxtBuf = 1'b0;
      end
    end else begin
      case (state)
        ST_IDLE: nxt = ST_FSTART;
        ST_FSTART: begin
          cmd.frameStart = 1'b1;
          cmd.bufSel = curBuf;
          nxt = ST_LOAD;
        end
        ST_LOAD: begin
          if (loadMode == MODE_PAL_PIX || loadMode == MODE_PAL_ONLY) begin
            cmd.startPal = 1'b1;
            nxt = ST_PAL;
          end else begin
            cmd.startData = 1'b1;
            nxt = ST_DATA;
          end
        end
        ST_PAL: begin
          if (canIssue) begin
            cmd.issue = 1'b1;
          end else if (phaseDone) begin
            cmd.palDone = 1'b1;
            if (loadMode == MODE_PAL_ONLY) begin
              nxt = ST_HALT;
            end else begin
              cmd.startData = 1'b1;
              cmd.contData = 1'b1;
              nxt = ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (canIssue) begin
            cmd.issue = 1'b1;
          end else if (phaseDone) begin
            cmd.eof0 = !curBuf;
            cmd.eof1 = curBuf;
            nxtBuf = dualEn ? !curBuf : 1'b0;
            nxt = ST_FSTART;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curBuf <= 1'b0;
    end else begin
      state <= nxt;
      curBuf <= nxtBuf;
    end
  end
endmodule

// File: rtl/frame_fetch_dma.sv
module frame_fetch_dma
  import fetch_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic             rdReq,
  output logic [31:0]      rdAddr,
  output logic [LEN_W-1:0] rdLen,
  input  logic             rdAck,
  input  logic             rspValid,
  input  logic [31:0]      rspData,
  output logic             palWrEn,
  output logic [6:0]       palWrIdx,
  output logic [31:0]      palWrData,
  input  logic             pixRd,
  output logic [31:0]      pixData,
  output logic             pixAvail,
  input  logic             lineStart,
  output logic [31:0]      statusOut,
  output logic             irq
);
  fetchCmd_t cmd;
  logic rasterEn, dualEn, windowEmpty, respIdle, canIssue;
  logic [1:0] loadMode;

  fetch_ctl u_ctl (
    .clk(clk), .rstN(rstN), .rasterEn(rasterEn), .loadMode(loadMode),
    .dualEn(dualEn), .windowEmpty(windowEmpty), .respIdle(respIdle),
    .canIssue(canIssue), .cmd(cmd)
  );

  fetch_dp #(.FIFO_DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .cmd(cmd), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdLen(rdLen), .rdAck(rdAck), .rspValid(rspValid), .rspData(rspData),
    .palWrEn(palWrEn), .palWrIdx(palWrIdx), .palWrData(palWrData),
    .pixRd(pixRd), .pixData(pixData), .pixAvail(pixAvail),
    .lineStart(lineStart), .statusOut(statusOut), .irq(irq),
    .rasterEn(rasterEn), .loadMode(loadMode), .dualEn(dualEn),
    .windowEmpty(windowEmpty), .respIdle(respIdle), .canIssue(canIssue)
  );
endmodule

// File: rtl/frame_fetch_dma_chk.sv
module frame_fetch_dma_chk #(
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             statWr,
  input logic             wrBit6,
  input logic             wrBit8,
  input logic             rdReq,
  input logic             rdAck,
  input logic [31:0]      rdAddr,
  input logic [LEN_W-1:0] rdLen,
  input logic             palWrEn,
  input logic [6:0]       palWrIdx,
  input logic             lineStart,
  input logic [31:0]      statusOut,
  input logic             irq
);
  // R3: an unacknowledged request keeps its address and length
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck |=> rdReq && $stable(rdAddr) && $stable(rdLen));

  // R3: a request is never empty and never longer than the largest burst
  p_len_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (rdLen != '0) && (32'(rdLen) <= 32'd16));

  // R5: palette indices rise by one across back-to-back writes
  p_pal_seq_r5: assert property (@(posedge clk) disable iff (!rstN)
    palWrEn && $past(palWrEn) |-> palWrIdx == $past(palWrIdx) + 7'd1);

  // R8: palette-done only drops after a write of one to its position
  p_w1c_pal_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusOut[6]) |-> $past(statWr && wrBit6));

  // R8: end-of-frame 0 only drops after a write of one to its position
  p_w1c_eof_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusOut[8]) |-> $past(statWr && wrBit8));

  // R11: sync-lost only rises on a line start
  p_sync_line_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[2]) |-> $past(lineStart));

  // R12: no interrupt without a status event
  p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut == 32'd0) |-> !irq);
endmodule

bind frame_fetch_dma frame_fetch_dma_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .statWr(regWr && regAddr == 3'd2),
  .wrBit6(regWrData[6]), .wrBit8(regWrData[8]),
  .rdReq(rdReq), .rdAck(rdAck), .rdAddr(rdAddr), .rdLen(rdLen),
  .palWrEn(palWrEn), .palWrIdx(palWrIdx), .lineStart(lineStart),
  .statusOut(statusOut), .irq(irq)
);

// File: tb/frame_fetch_dma_tb.sv
module frame_fetch_dma_tb;
  localparam int DEPTH = 16;
  localparam int LW = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWr = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic rdReq, rdAck = 1'b0, rspValid = 1'b0;
  logic [31:0] rdAddr, rspData = '0;
  logic [LW-1:0] rdLen;
  logic palWrEn, pixAvail, irq, pixRd = 1'b0, lineStart = 1'b0;
  logic [6:0] palWrIdx;
  logic [31:0] palWrData, pixData, statusOut;

  int checks = 0, errors = 0;
  int reqCount = 0, maxLen = 0, ackDelay = 0;
  int gotN = 0, palN = 0;
  logic [31:0] got [1024];
  logic [31:0] palDat [256];
  logic [6:0] palIdxA [256];
  bit consume = 0, forceRd = 0;
  logic [31:0] eB0, eB1;
  int eW0, eW1;
  bit eDual;

  always #10 clk = ~clk;

  frame_fetch_dma #(.FIFO_DEPTH(DEPTH), .LEN_W(LW)) u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .rdReq(rdReq), .rdAddr(rdAddr), .rdLen(rdLen),
    .rdAck(rdAck), .rspValid(rspValid), .rspData(rspData),
    .palWrEn(palWrEn), .palWrIdx(palWrIdx), .palWrData(palWrData),
    .pixRd(pixRd), .pixData(pixData), .pixAvail(pixAvail),
    .lineStart(lineStart), .statusOut(statusOut), .irq(irq)
  );

  // Memory model: each word returns its own byte address
  initial begin
    logic [31:0] mAddr;
    int mLen, mCnt, waitCnt;
    bit busy;
    busy = 0; waitCnt = 0; mAddr = '0; mLen = 0; mCnt = 0;
    forever begin
      @(negedge clk);
      rdAck = 1'b0;
      rspValid = 1'b0;
      if (busy) begin
        rspValid = 1'b1;
        rspData = mAddr + 32'(4 * mCnt);
        mCnt++;
        if (mCnt == mLen) busy = 0;
      end else if (rdReq) begin
        if (waitCnt < ackDelay) begin
          waitCnt++;
        end else begin
          waitCnt = 0;
          rdAck = 1'b1;
          mAddr = rdAddr;
          mLen = int'(rdLen);
          mCnt = 0;
          busy = 1;
          reqCount++;
          if (mLen > maxLen) maxLen = mLen;
        end
      end
    end
  end

  // Pixel consumer and palette recorder
  initial begin
    forever begin
      @(negedge clk);
      pixRd = 1'b0;
      if (forceRd) pixRd = 1'b1;
      else if (consume && pixAvail) begin
        pixRd = 1'b1;
        if (gotN < 1024) got[gotN] = pixData;
        gotN++;
      end
      if (palWrEn && palN < 256) begin
        palIdxA[palN] = palWrIdx;
        palDat[palN] = palWrData;
        palN++;
      end
    end
  end

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete actual=%0d expected=0", 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic waitGot(input int n);
    for (int k = 0; k < 4000 && gotN < n; k++) @(negedge clk);
  endtask

  // Disable, clear status and bench records, load windows and setup
  task automatic setupRun(input logic [31:0] setup, input logic [31:0] b0,
                          input logic [31:0] c0, input logic [31:0] b1,
                          input logic [31:0] c1);
    consume = 0;
    wrReg(3'd0, 32'd0);
    repeat (40) @(negedge clk);
    wrReg(3'd2, 32'h3FF);
    wrReg(3'd1, setup);
    wrReg(3'd3, b0); wrReg(3'd4, c0);
    wrReg(3'd5, b1); wrReg(3'd6, c1);
    gotN = 0; palN = 0; reqCount = 0; maxLen = 0;
  endtask

  function automatic logic [31:0] expWord(input int i);
    int period, p;
    period = eDual ? eW0 + eW1 : eW0;
    p = i % period;
    return (p < eW0) ? eB0 + 32'(4 * p) : eB1 + 32'(4 * (p - eW0));
  endfunction

  task automatic checkSeq(input int n, input string req);
    int bad, firstBad;
    bad = 0; firstBad = -1;
    for (int i = 0; i < n; i++) begin
      if (got[i] !== expWord(i)) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
    end
    if (firstBad < 0) chk(1, req, 0, 0);
    else chk(0, req, got[firstBad], expWord(firstBad));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(statusOut == 0, "R1 status", statusOut, 0);
    chk(!irq && !rdReq && !pixAvail, "R1 outputs", {irq, rdReq, pixAvail}, 0);

    // R2/R3: pixel-only sweep over burst codes and window lengths
    for (int code = 0; code < 6; code++) begin
      for (int wi = 0; wi < 3; wi++) begin
        int w, b, expMax;
        w = (wi == 0) ? 5 : (wi == 1) ? 12 : 16;
        b = (code >= 4) ? 16 : (1 << code);
        expMax = (b < w) ? b : w;
        ackDelay = (code == 0 && wi == 0) ? 2 : 0;
        setupRun(32'(code) << 4, 32'h1000, 32'h1000 + 32'(4 * w - 1), 0, 0);
        eB0 = 32'h1000; eW0 = w; eDual = 0; eB1 = 0; eW1 = 0;
        consume = 1;
        wrReg(3'd0, 32'h0020_0001);
        waitGot(2 * w);
        consume = 0;
        checkSeq(2 * w, "R2 pixel-only sequence");
        chk(maxLen == expMax, "R3 burst length", maxLen, expMax);
        chk(statusOut[8], "R2 end-of-frame 0", statusOut[8], 1);
      end
    end
    ackDelay = 0;

    // R4: alternating buffers
    setupRun(32'h21, 32'h2000, 32'h2017, 32'h3000, 32'h300F);
    eB0 = 32'h2000; eW0 = 6; eB1 = 32'h3000; eW1 = 4; eDual = 1;
    consume = 1;
    wrReg(3'd0, 32'h0020_0001);
    waitGot(16);
    consume = 0;
    checkSeq(16, "R4 alternation order");
    chk(statusOut[9:8] == 2'b11, "R4 both end-of-frame bits", statusOut[9:8], 3);
    wrReg(3'd0, 32'd0);
    repeat (40) @(negedge clk);
    // R8: zero write ignored, one write clears only its bit
    wrReg(3'd2, 32'd0);
    @(negedge clk);
    chk(statusOut[9:8] == 2'b11, "R8 zero write ignored", statusOut[9:8], 3);
    wrReg(3'd2, 32'h100);
    @(negedge clk);
    chk(statusOut[9:8] == 2'b10, "R8 one write clears bit 8", statusOut[9:8], 2);
    // R13: disabled block stays quiet
    begin
      int snap;
      snap = reqCount;
      repeat (50) @(negedge clk);
      chk(reqCount == snap && !pixAvail, "R13 no fetch while off", reqCount, snap);
    end

    // R5/R7: palette plus pixels, small palette
    setupRun(32'h20, 32'h4000, 32'h4037, 0, 0);
    consume = 1;
    wrReg(3'd0, 32'h0000_0001);
    waitGot(12);
    consume = 0;
    eB0 = 32'h4020; eW0 = 6; eDual = 0;
    checkSeq(12, "R5 pixels follow palette");
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 8; i++)
        if (palIdxA[i] != 7'(i) || palDat[i] != 32'h4000 + 32'(4 * i)) bad++;
      chk(bad == 0, "R5 palette words and indices", bad, 0);
    end
    chk(palN >= 16 && palIdxA[8] == 0, "R7 small palette is 8 words per frame",
        palIdxA[8], 0);
    chk(statusOut[6], "R5 palette-done bit", statusOut[6], 1);

    // R6/R7: palette only, large palette
    setupRun(32'h40, 32'h8000, 32'h8FFF, 0, 0);
    wrReg(3'd0, 32'h0050_0001);
    repeat (600) @(negedge clk);
    chk(palN == 128, "R7 large palette is 128 words", palN, 128);
    chk(reqCount == 8, "R6 requests for palette only", reqCount, 8);
    chk(!pixAvail && statusOut[6], "R6 no pixels and palette done",
        {pixAvail, statusOut[6]}, 1);
    chk(palDat[127] == 32'h81FC, "R6 last palette word", palDat[127], 32'h81FC);

    // R9: window rewrite during the first frame applies from the second
    setupRun(32'h00, 32'h5000, 32'h501F, 0, 0);
    wrReg(3'd0, 32'h0020_0001);
    repeat (4) @(negedge clk);
    wrReg(3'd3, 32'h6000);
    wrReg(3'd4, 32'h601F);
    consume = 1;
    waitGot(16);
    consume = 0;
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 16; i++)
        if (got[i] != ((i < 8) ? 32'h5000 + 32'(4 * i) : 32'h6000 + 32'(4 * (i - 8)))) bad++;
      chk(bad == 0, "R9 rewrite takes effect next frame", bad, 0);
    end

    // R10/R11/R12: underflow and sync-lost with an empty FIFO
    setupRun(32'h30, 32'h7000, 32'h701F, 0, 0);
    wrReg(3'd0, 32'h0010_0001);
    repeat (80) @(negedge clk);
    @(negedge clk); lineStart = 1'b1;
    @(negedge clk); lineStart = 1'b0;
    chk(!statusOut[2], "R11 no sync-lost without underflow", statusOut[2], 0);
    @(posedge clk); forceRd = 1;
    @(posedge clk); forceRd = 0;
    @(negedge clk); @(negedge clk);
    chk(statusOut[5], "R10 underflow bit", statusOut[5], 1);
    @(negedge clk); lineStart = 1'b1;
    @(negedge clk); lineStart = 1'b0;
    chk(statusOut[2], "R11 sync-lost on next line", statusOut[2], 1);
    chk(!irq, "R12 masked interrupt", irq, 0);
    wrReg(3'd0, 32'h0010_0041);
    @(negedge clk);
    chk(irq, "R12 underflow enable", irq, 1);
    wrReg(3'd2, 32'h24);
    @(negedge clk);
    chk(!irq && statusOut[6], "R12 cleared underflow drops irq", irq, 0);
    wrReg(3'd0, 32'h0010_0051);
    @(negedge clk);
    chk(irq, "R12 palette-done enable", irq, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule